// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes the place of a software routine that brings a DDR SDRAM device out of power-up. After reset it waits in an idle state with clock enable low and the command pins deselected. A single-cycle `start` pulse then launches a fixed series of steps. The first step raises clock enable without issuing a command. The block then sends a precharge-all and loads the extended mode register on bank 1. It loads the mode register with the DLL reset bit set, sends a second precharge-all, issues two auto-refresh commands, and loads the mode register again without DLL reset. A programmed wait follows each step.

Each wait is given as a number of units, and one unit is `DELAY_SCALE` clock cycles, so one set of unit counts works at different clock rates. When the last wait expires, `done` goes high and stays high until the next reset. From then on the command pins stay at NOP and clock enable stays high, so a controller can take over the pins. The block has no data path and no handshake: `start` and `done` are plain control pins.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is active, and in the idle state after reset, `cke` and `done` are 0, `{cs_n,ras_n,cas_n,we_n}` is 4'b1111 (deselect), and `addr` and `bank` are 0.
- R2: If `start` is high at a rising edge while the block is idle, then in the next cycle `cke` is 1, the command pins read 4'b1111, and `addr` and `bank` are 0. This is the clock-enable step.
- R3: Precharge-all is encoded on `{cs_n,ras_n,cas_n,we_n}` as 4'b0010 with `addr` 13'h0400. Auto-refresh is encoded as 4'b0001 with `addr` 0. A mode register load is encoded as 4'b0000.
- R4: After the clock-enable step, exactly seven commands are issued, in this order: precharge-all, extended mode load, mode load with `addr` 13'h0132, precharge-all, auto-refresh, auto-refresh, mode load with `addr` 13'h0032.
- R5: `bank` is 1 only during the extended mode load, which uses `addr` 0. In every other cycle, including every NOP cycle, `addr` and `bank` are 0 unless R3 or R4 gives another value.
- R6: Each command is driven for exactly one cycle, and the cycle after it is a NOP (4'b1111). This holds when every unit count and `DELAY_SCALE` is at least 1.
- R7: A step is followed by a wait of W·`DELAY_SCALE` cycles, where W is that step's unit count. The next step therefore starts 1 + W·`DELAY_SCALE` cycles after the previous one. The unit counts are: clock-enable `T_CKE`, each precharge `T_PRE`, extended mode load `T_EMR`, each mode load `T_MR` (default 200), each refresh `T_REF` (default 4).
- R8: `done` rises 1 + `T_MR`·`DELAY_SCALE` cycles after the final mode load. It then stays at 1, with `cke` at 1 and the command pins at 4'b1111.
- R9: A `start` pulse has no effect while the sequence is running or after `done` has gone high. Timing and outputs are unchanged.
- R10: An active-low reset asserted at any point returns the block at once to the R1 state. A later `start` runs the whole sequence again from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the sequence when the block is idle |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W (13) | DRAM address |
| bank | output | BANK_W (2) | DRAM bank address |
| done | output | 1 | Initialization finished (sticky) |

## Verification
The assertions assume that every unit count and `DELAY_SCALE` is at least 1, so that a NOP always separates two commands. They also assume that `start` is a synchronous input that may stay high for any number of cycles. The bench drives `start` and `rst_n` only at falling clock edges. It fires stray `start` pulses at random during the waits and after completion, and asserts reset at a random cycle in the middle of a run. The parameters it uses keep every wait non-zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  // Command pins packed as {cs_n, ras_n, cas_n, we_n}
  typedef logic [3:0] cmd_t;
  localparam cmd_t CMD_NOP = 4'b1111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_MRS = 4'b0000;
  localparam cmd_t CMD_REF = 4'b0001;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_t;

  localparam int NSTEPS = 8;

  typedef enum logic [2:0] {
    SP_CKE, SP_PRE1, SP_EMR, SP_MR_DLL, SP_PRE2, SP_REF1, SP_REF2, SP_MR_RUN
  } step_t;

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int CW          = 10,
  parameter int DELAY_SCALE = 1,
  parameter int T_CKE       = 2,
  parameter int T_PRE       = 1,
  parameter int T_EMR       = 1,
  parameter int T_MR        = 200,
  parameter int T_REF       = 4,
  parameter logic [ADDR_W-1:0] PRE_ALL_WORD = 13'h0400,
  parameter logic [ADDR_W-1:0] MR_DLL_WORD  = 13'h0132,
  parameter logic [ADDR_W-1:0] MR_RUN_WORD  = 13'h0032
) (
  input  step_t             step,
  output cmd_t              cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [CW-1:0]     wait_cyc
);

  function automatic int units_of(int s);
    case (s)
      0:       return T_CKE;
      1, 4:    return T_PRE;
      2:       return T_EMR;
      3, 7:    return T_MR;
      5, 6:    return T_REF;
      default: return 0;
    endcase
  endfunction

  function automatic cmd_t cmd_of(int s);
    case (s)
      1, 4:    return CMD_PRE;
      2, 3, 7: return CMD_MRS;
      5, 6:    return CMD_REF;
      default: return CMD_NOP;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(int s);
    case (s)
      1, 4:    return PRE_ALL_WORD;
      3:       return MR_DLL_WORD;
      7:       return MR_RUN_WORD;
      default: return '0;
    endcase
  endfunction

  logic [CW-1:0]     wait_tab [NSTEPS];
  cmd_t              cmd_tab  [NSTEPS];
  logic [ADDR_W-1:0] addr_tab [NSTEPS];
  logic [BANK_W-1:0] bank_tab [NSTEPS];

  for (genvar g = 0; g < NSTEPS; g++) begin : g_tab
    assign wait_tab[g] = CW'(units_of(g) * DELAY_SCALE);
    assign cmd_tab[g]  = cmd_of(g);
    assign addr_tab[g] = addr_of(g);
    assign bank_tab[g] = (g == 2) ? BANK_W'(1) : '0;
  end

  assign cmd      = cmd_tab[step];
  assign addr     = addr_tab[step];
  assign bank     = bank_tab[step];
  assign wait_cyc = wait_tab[step];

endmodule

// File: rtl/ddr_init_wait_timer.sv
module ddr_init_wait_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign last = (count == CW'(1));

  // R7: a running wait counts down by exactly one each cycle
  a_r7_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   wait_zero,
  input  logic   timer_last,
  output state_t state,
  output step_t  step,
  output logic   timer_load
);

  state_t state_d;
  step_t  step_d;
  logic   final_step;

  assign final_step = (step == SP_MR_RUN);

  always_comb begin
    state_d = state;
    step_d  = step;
    case (state)
      ST_IDLE: if (start) begin
        state_d = ST_ISSUE;
        step_d  = SP_CKE;
      end
      ST_ISSUE: begin
        if (!wait_zero)      state_d = ST_WAIT;
        else if (final_step) state_d = ST_DONE;
        else                 step_d  = step_t'(step + 3'd1);
      end
      ST_WAIT: if (timer_last) begin
        if (final_step) state_d = ST_DONE;
        else begin
          state_d = ST_ISSUE;
          step_d  = step_t'(step + 3'd1);
        end
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= SP_CKE;
    end else begin
      state <= state_d;
      step  <= step_d;
    end
  end

  assign timer_load = (state == ST_ISSUE) && !wait_zero;

  // R9: once left, idle is never re-entered without reset
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_IDLE));

  // R4: steps advance by one at a time, never skipping
  a_r4_step_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ISSUE && $past(state) != ST_IDLE) |-> (step == step_t'($past(step) + 3'd1)));

  // R8: completion is sticky
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> (state == ST_DONE));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BANK_W      = 2,
  parameter int DELAY_SCALE = 1,
  parameter int T_CKE       = 2,
  parameter int T_PRE       = 1,
  parameter int T_EMR       = 1,
  parameter int T_MR        = 200,
  parameter int T_REF       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic              done
);

  localparam int MAX_A     = (T_CKE > T_PRE) ? T_CKE : T_PRE;
  localparam int MAX_B     = (T_EMR > T_MR)  ? T_EMR : T_MR;
  localparam int MAX_C     = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_UNITS = (MAX_C > T_REF) ? MAX_C : T_REF;
  localparam int CW        = $clog2(MAX_UNITS * DELAY_SCALE + 1) + 1;

  state_t            state;
  step_t             step;
  cmd_t              rom_cmd;
  logic [ADDR_W-1:0] rom_addr;
  logic [BANK_W-1:0] rom_bank;
  logic [CW-1:0]     wait_cyc;
  logic              timer_load;
  logic              timer_last;
  logic              issuing;
  cmd_t              pins;

  ddr_init_step_rom #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CW(CW), .DELAY_SCALE(DELAY_SCALE),
    .T_CKE(T_CKE), .T_PRE(T_PRE), .T_EMR(T_EMR), .T_MR(T_MR), .T_REF(T_REF)
  ) u_rom (
    .step(step), .cmd(rom_cmd), .addr(rom_addr), .bank(rom_bank), .wait_cyc(wait_cyc)
  );

  ddr_init_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(wait_cyc), .last(timer_last)
  );

  ddr_init_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_zero(wait_cyc == '0),
    .timer_last(timer_last), .state(state), .step(step), .timer_load(timer_load)
  );

  assign issuing = (state == ST_ISSUE);
  assign pins    = issuing ? rom_cmd : CMD_NOP;
  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign addr    = issuing ? rom_addr : '0;
  assign bank    = issuing ? rom_bank : '0;
  assign cke     = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  // R6: a command lasts one cycle and is followed by NOP
  a_r6_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R5: non-zero bank only on a mode register load
  a_r5_bank_emr_only: assert property (@(posedge clk) disable iff (!rst_n)
    (bank != '0) |-> ({cs_n, ras_n, cas_n, we_n} == CMD_MRS));

  // R3: every command in the series asserts the row strobe
  a_r3_ras_in_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ras_n);

  // R8: after completion the pins stay quiet with clock enable high
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && cke && done));

  // R1: clock enable low implies deselect
  a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cs_n && !done && addr == '0));

endmodule

// File: tb/ddr_init_seq_bench.sv
module ddr_init_seq_bench;

  localparam int S     = 2;
  localparam int T_CKE = 2;
  localparam int T_PRE = 1;
  localparam int T_EMR = 1;
  localparam int T_MR  = 200;
  localparam int T_REF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [12:0] addr;
  logic [1:0]  bank;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .DELAY_SCALE(S), .T_CKE(T_CKE), .T_PRE(T_PRE), .T_EMR(T_EMR),
    .T_MR(T_MR), .T_REF(T_REF)
  ) u_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .bank(bank), .done(done)
  );

  localparam logic [20:0] IDLE_V = {1'b0, 4'b1111, 13'd0, 2'd0, 1'b0};

  function automatic int units(int s);
    case (s)
      0: return T_CKE;
      1, 4: return T_PRE;
      2: return T_EMR;
      3, 7: return T_MR;
      default: return T_REF;
    endcase
  endfunction

  function automatic int cyc_of(int s);
    int c = 0;
    for (int i = 0; i < s; i++) c += 1 + units(i) * S;
    return c;
  endfunction

  function automatic int done_at();
    return cyc_of(7) + 1 + units(7) * S;
  endfunction

  function automatic int step_at(int n);
    for (int i = 0; i < 8; i++) if (cyc_of(i) == n) return i;
    return -1;
  endfunction

  function automatic logic [20:0] exp_at(int n);
    int s = step_at(n);
    logic [3:0] c = 4'b1111;
    logic [12:0] a = 13'd0;
    logic [1:0] b = 2'd0;
    case (s)
      1, 4: begin c = 4'b0010; a = 13'h0400; end
      2:    begin c = 4'b0000; b = 2'd1; end
      3:    begin c = 4'b0000; a = 13'h0132; end
      5, 6: c = 4'b0001;
      7:    begin c = 4'b0000; a = 13'h0032; end
      default: ;
    endcase
    return {1'b1, c, a, b, (n >= done_at()) ? 1'b1 : 1'b0};
  endfunction

  function automatic string tag_at(int n, bit stray);
    int s = step_at(n);
    if (stray) return "R9";
    if (n >= done_at()) return "R8";
    case (s)
      0: return "R2";
      1, 4, 5, 6: return "R3";
      2: return "R5";
      3, 7: return "R4";
      default: ;
    endcase
    if (step_at(n - 1) > 0) return "R6";
    return "R7";
  endfunction

  function automatic logic [20:0] act();
    return {cke, cs_n, ras_n, cas_n, we_n, addr, bank, done};
  endfunction

  task automatic check(string tag, int n, logic [20:0] a, logic [20:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, a, e);
    end
  endtask

  task automatic run_seq(int stray_pct, int reset_at, string idle_tag);
    bit stray = 0;
    int gap = 1 + ($urandom % 4);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check(idle_tag, -1, act(), IDLE_V);
    end
    start = 1'b1;
    for (int n = 0; n <= done_at() + 8; n++) begin
      @(negedge clk);
      if (n == reset_at) begin
        rst_n = 1'b0;
        #1 check("R10", n, act(), IDLE_V);
        @(negedge clk);
        check("R10", n + 1, act(), IDLE_V);
        rst_n = 1'b1;
        start = 1'b0;
        return;
      end
      check(tag_at(n, stray), n, act(), exp_at(n));
      stray = (n > 0) && (($urandom % 100) < stray_pct);
      start = stray;
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", -1, act(), IDLE_V);
    rst_n = 1'b1;
    // R2 R4 R7 R8: directed run without stray starts
    run_seq(0, -1, "R1");
    // R9: stray starts during the run and after done
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", -1, act(), IDLE_V);
    rst_n = 1'b1;
    run_seq(15, -1, "R1");
    // R10: reset in the middle of a wait, then a clean rerun
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(10, 5 + ($urandom % 300), "R1");
    run_seq(20, -1, "R10");
    // R10: reset exactly on a command cycle
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_seq(0, cyc_of(5), "R1");
    run_seq(0, -1, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule